// File: doc/BRIEF.md
# Programmable One-Shot Countdown Timer

A local interrupt timer with a small register port. Software picks a prescale ratio, optionally masks the interrupt, and writes a 32-bit start value. The current count then falls by one each time the prescaler completes a period of bus clock cycles. While the timer runs, software can read the remaining count at any time, so the ticks elapsed are the start value minus the value read.

When the count reaches zero the timer stops there and raises a single-cycle interrupt pulse, unless the interrupt is masked. A new start value restarts the countdown, and a start value of zero halts it. The prescaler restarts whenever the start value or the divide setting is written. The first decrement therefore comes one full divide period after the write.

Top module: `one_shot_timer`

## Requirements
- R1: After reset the current count, the start value and the divide setting read 0, the control register reads 0x0001_0000 (masked), and `irq_o` is low.
- R2: A write to offset 0x1 stores the start value, loads it into the current count, and restarts the prescaler. The first decrement lands on the clock edge that is D cycles after the write edge, where D is the divide ratio.
- R3: The divide setting is at offset 0x3, bits 3:0. Its codes are 0xB to 1, 0x0 to 2, 0x1 to 4, 0x2 to 8, 0x3 to 16, 0x8 to 32, 0x9 to 64 and 0xA to 128.
- R4: Bit 2 of the divide setting has no effect: 0x4 divides like 0x0, and 0xF divides like 0xB. The register reads back the 4-bit value as written.
- R5: The current count at offset 0x2 can be read while running. It falls by exactly one per D bus cycles, with no other change unless a register is written.
- R6: When the count steps from 1 to 0, `irq_o` is high for exactly the one cycle in which the count first reads 0. The count then holds 0 with no further pulse.
- R7: Control bit 16 is the mask. When it is set, expiry raises no interrupt, but counting still runs down to 0.
- R8: Writing 0 to the start value sets the current count to 0 and stops it, with no interrupt.
- R9: A start-value write while running restarts from the new value. A divide-setting write restarts the prescaler without changing the count.
- R10: A start value of 0xFFFF_FFFF loads and counts down like any other value.
- R11: Writes to offset 0x2 or to unused offsets (0x4 and above) change nothing. Unused offsets read 0.
- R12: The control register at offset 0x0 keeps a vector in bits 7:0, the mask in bit 16 and a mode field in bits 18:17. Only the one-shot behaviour is implemented, and other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register offset |
| we_i | input | 1 | Write strobe, taken on the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Expiry pulse, one cycle |

## Verification
The properties assume that one register access happens per cycle and that the count is changed only by a start-value write or a prescaler tick. From those assumptions the count may fall by at most one per cycle, and a pulse needs the count to have been 1 on the previous cycle. The stimulus meets this because all writes go through a single write task that holds `we_i` for one edge and then parks the address on the current count. Every divide code, including the codes with bit 2 set, is driven only through offset 0x3. The bench model computes the expected count from the cycles elapsed since the last restart, not from a prescaler copy.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned OFS_CTL  = 0;
  localparam int unsigned OFS_INIT = 1;
  localparam int unsigned OFS_CUR  = 2;
  localparam int unsigned OFS_DIV  = 3;

  localparam int unsigned CTL_VEC_W    = 8;
  localparam int unsigned CTL_MASK_BIT = 16;
  localparam int unsigned CTL_MODE_LSB = 17;
  localparam int unsigned CTL_MODE_W   = 2;
  localparam int unsigned DIV_W        = 4;

  typedef struct packed {
    logic [CTL_MODE_W-1:0] mode;
    logic                  mask;
    logic [CTL_VEC_W-1:0]  vec;
  } ctl_t;

  // sel = {code[3], code[1], code[0]}; 3'b111 is divide-by-1
  function automatic logic [2:0] div_shift(input logic [2:0] sel);
    return (sel == 3'b111) ? 3'd0 : sel + 3'd1;
  endfunction
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] cur_i,
  output ctl_t              ctl_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              init_wr_o,
  output logic              div_wr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] init_q;
  logic              ctl_wr;

  assign ctl_wr    = we_i && (addr_i == ADDR_W'(OFS_CTL));
  assign init_wr_o = we_i && (addr_i == ADDR_W'(OFS_INIT));
  assign div_wr_o  = we_i && (addr_i == ADDR_W'(OFS_DIV));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_o  <= '{mode: '0, mask: 1'b1, vec: '0};
      div_o  <= '0;
      init_q <= '0;
    end else begin
      if (ctl_wr) begin
        ctl_o.vec  <= wdata_i[CTL_VEC_W-1:0];
        ctl_o.mask <= wdata_i[CTL_MASK_BIT];
        ctl_o.mode <= wdata_i[CTL_MODE_LSB +: CTL_MODE_W];
      end
      if (div_wr_o)  div_o  <= wdata_i[DIV_W-1:0];
      if (init_wr_o) init_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_W'(OFS_CTL): begin
        rdata_o[CTL_VEC_W-1:0]                 = ctl_o.vec;
        rdata_o[CTL_MASK_BIT]                  = ctl_o.mask;
        rdata_o[CTL_MODE_LSB +: CTL_MODE_W]    = ctl_o.mode;
      end
      ADDR_W'(OFS_INIT): rdata_o = init_q;
      ADDR_W'(OFS_CUR):  rdata_o = cur_i;
      ADDR_W'(OFS_DIV):  rdata_o[DIV_W-1:0] = div_o;
      default:           rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
#(
  parameter int unsigned PRE_W = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] limit;

  assign limit  = (PRE_W'(1) << div_shift(sel_i)) - PRE_W'(1);
  assign tick_o = (pre_q == limit) && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  pre_q <= '0;
    else if (restart_i || tick_o) pre_q <= '0;
    else                          pre_q <= pre_q + PRE_W'(1);
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic              tick_i,
  input  logic              mask_i,
  output logic [DATA_W-1:0] cur_o,
  output logic              irq_o
);
  logic step;
  assign step = tick_i && (cur_o != '0) && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_o <= '0;
      irq_o <= 1'b0;
    end else begin
      if (load_i)    cur_o <= load_val_i;
      else if (step) cur_o <= cur_o - DATA_W'(1);
      irq_o <= step && (cur_o == DATA_W'(1)) && !mask_i;
    end
  end
endmodule

// File: rtl/one_shot_timer.sv
module one_shot_timer
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned PRE_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  ctl_t              ctl;
  logic [DIV_W-1:0]  div_code;
  logic              init_wr, div_wr, tick, mask;
  logic [DATA_W-1:0] cur_q;

  assign mask = ctl.mask;

  tmr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i,
    .cur_i(cur_q), .ctl_o(ctl), .div_o(div_code),
    .init_wr_o(init_wr), .div_wr_o(div_wr), .rdata_o
  );

  tmr_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk_i, .rst_ni,
    .restart_i(init_wr || div_wr),
    .sel_i({div_code[3], div_code[1], div_code[0]}),
    .tick_o(tick)
  );

  tmr_count #(.DATA_W(DATA_W)) u_cnt (
    .clk_i, .rst_ni,
    .load_i(init_wr), .load_val_i(wdata_i),
    .tick_i(tick), .mask_i(mask),
    .cur_o(cur_q), .irq_o
  );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              init_wr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] cur_i,
  input logic              mask_i,
  input logic              irq_i
);
  // R2
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_wr_i |=> cur_i == $past(wdata_i));
  // R5
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_wr_i && cur_i != '0) |=>
      (cur_i == $past(cur_i) || cur_i == $past(cur_i) - DATA_W'(1)));
  // R6
  hold_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_wr_i && cur_i == '0) |=> cur_i == '0);
  // R6
  irq_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (cur_i == '0 && $past(cur_i) == DATA_W'(1)));
  // R6
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> !irq_i);
  // R7
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> !$past(mask_i));
endmodule

bind one_shot_timer tmr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .init_wr_i(init_wr), .wdata_i(wdata_i),
  .cur_i(cur_q), .mask_i(mask), .irq_i(irq_o)
);

// File: tb/one_shot_timer_bench.sv
module one_shot_timer_bench;
  timeunit 1ns; timeprecision 1ps;

  logic        clk_i = 1'b0, rst_ni = 1'b0, we_i = 1'b0;
  logic [3:0]  addr_i = 4'h2;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;
  int checks = 0, errors = 0;
  bit live = 0;

  always #10 clk_i = ~clk_i;

  one_shot_timer u_one_shot_timer (.*);

  // behavioural model: count = base - elapsed/D, floored at zero
  longint m_base, m_n;
  logic [31:0] m_ctl, m_init;
  logic [3:0]  m_div;
  logic        m_irq;

  function automatic longint div_of(input logic [3:0] c);
    case (c & 4'hB)
      4'h0: return 2;   4'h1: return 4;   4'h2: return 8;  4'h3: return 16;
      4'h8: return 32;  4'h9: return 64;  4'hA: return 128;
      default: return 1;
    endcase
  endfunction

  function automatic longint m_cur();
    longint t = m_n / div_of(m_div);
    return (t >= m_base) ? 0 : m_base - t;
  endfunction

  function automatic logic [31:0] m_read(input logic [3:0] a);
    case (a)
      4'h0: return m_ctl;
      4'h1: return m_init;
      4'h2: return 32'(m_cur());
      4'h3: return {28'h0, m_div};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_base = 0; m_n = 0; m_ctl = 32'h0001_0000; m_init = 0; m_div = 0; m_irq = 0;
    end else begin
      longint prev, now;
      bit ld;
      prev = m_cur();
      ld = we_i && addr_i == 4'h1;
      if (ld) begin m_base = longint'(wdata_i); m_n = 0; m_init = wdata_i; end
      else if (we_i && addr_i == 4'h3) begin m_base = prev; m_n = 0; m_div = wdata_i[3:0]; end
      else m_n++;
      now = m_cur();
      m_irq = !ld && prev != 0 && now == 0 && !m_ctl[16];
      if (we_i && addr_i == 4'h0) m_ctl = wdata_i & 32'h0007_00FF;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) if (live) begin
    chk("R5 rdata vs model", rdata_o, m_read(addr_i));
    chk("R6 irq vs model", {31'h0, irq_o}, {31'h0, m_irq});
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk_i); #2; addr_i = a; we_i = 1'b1; wdata_i = d;
    @(posedge clk_i); #2; we_i = 1'b0; addr_i = 4'h2;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr_i = a; @(negedge clk_i); d = rdata_o; #1 addr_i = 4'h2;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) begin @(posedge clk_i); #2; end
  endtask

  // cycles from the write edge until irq is seen
  task automatic cycles_to_irq(output int k);
    k = 0;
    for (int i = 1; i <= 2000; i++) begin
      @(posedge clk_i); #2;
      if (irq_o) begin k = i; break; end
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int k;
    logic [3:0] codes [8] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h8, 4'h9, 4'hA, 4'hB};
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    live = 1;
    // R1
    rd(4'h0, v); chk("R1 ctl reset", v, 32'h0001_0000);
    rd(4'h1, v); chk("R1 init reset", v, 32'h0);
    rd(4'h2, v); chk("R1 cur reset", v, 32'h0);
    rd(4'h3, v); chk("R1 div reset", v, 32'h0);
    chk("R1 irq reset", {31'h0, irq_o}, 32'h0);
    // R12
    wr(4'h0, 32'hFFFF_FFA5); rd(4'h0, v); chk("R12 ctl layout", v, 32'h0007_00A5);
    wr(4'h0, 32'h0000_0020); rd(4'h0, v); chk("R12 ctl unmask", v, 32'h0000_0020);
    // R3 R2: irq lands 3*D cycles after a load of 3
    foreach (codes[i]) begin
      wr(4'h3, {28'h0, codes[i]});
      wr(4'h1, 32'd3);
      cycles_to_irq(k);
      chk($sformatf("R3 code %h period", codes[i]), k, 32'(3 * div_of(codes[i])));
    end
    // R6: pulse ends, count holds zero
    wait_cyc(1); chk("R6 pulse one cycle", {31'h0, irq_o}, 32'h0);
    wait_cyc(5); rd(4'h2, v); chk("R6 holds zero", v, 32'h0);
    // R4
    wr(4'h3, 32'h4); rd(4'h3, v); chk("R4 readback 4", v, 32'h4);
    wr(4'h1, 32'd2); cycles_to_irq(k); chk("R4 code 4 acts as 0", k, 32'd4);
    wr(4'h3, 32'hF); rd(4'h3, v); chk("R4 readback F", v, 32'hF);
    wr(4'h1, 32'd5); cycles_to_irq(k); chk("R4 code F acts as B", k, 32'd5);
    // R5: D=8, 24 cycles -> 3 ticks
    wr(4'h3, 32'h2); wr(4'h1, 32'd50); wait_cyc(24);
    rd(4'h2, v); chk("R5 three ticks", v, 32'd47);
    // R9: divide write restarts prescaler, count kept
    wait_cyc(3); wr(4'h3, 32'h2); rd(4'h2, v); chk("R9 div write keeps count", v, 32'd47);
    wait_cyc(7); rd(4'h2, v); chk("R9 prescaler restarted", v, 32'd47);
    // R9: reload mid-run
    wr(4'h3, 32'h0); wr(4'h1, 32'd10); wait_cyc(7);
    wr(4'h1, 32'd10); rd(4'h2, v); chk("R9 reload", v, 32'd10);
    cycles_to_irq(k); chk("R9 restart period", k, 32'd20);
    // R7
    wr(4'h0, 32'h0001_0020); wr(4'h3, 32'hB); wr(4'h1, 32'd5);
    k = 0;
    for (int i = 0; i < 12; i++) begin wait_cyc(1); if (irq_o) k++; end
    chk("R7 masked no irq", k, 32'd0);
    rd(4'h2, v); chk("R7 masked still counts", v, 32'd0);
    // R8
    wr(4'h0, 32'h0000_0020); wr(4'h1, 32'd100); wait_cyc(10);
    wr(4'h1, 32'd0); rd(4'h2, v); chk("R8 stop", v, 32'd0);
    k = 0;
    for (int i = 0; i < 20; i++) begin wait_cyc(1); if (irq_o) k++; end
    chk("R8 no irq on stop", k, 32'd0);
    // R10
    wr(4'h1, 32'hFFFF_FFFF); wait_cyc(5); rd(4'h2, v);
    chk("R10 max load", v, 32'hFFFF_FFFA);
    // R11
    wr(4'h2, 32'd7); rd(4'h2, v); chk("R11 cur write ignored", v, 32'hFFFF_FFFA - 32'd2);
    wr(4'h9, 32'hFFFF_FFFF); rd(4'h9, v); chk("R11 unused reads zero", v, 32'h0);
    rd(4'h0, v); chk("R11 unused write ignored", v, 32'h0000_0020);
    rd(4'h3, v); chk("R11 div untouched", v, 32'hB);
    wr(4'h1, 32'd0);
    wait_cyc(2);
    live = 0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule